// File: doc/BRIEF.md
# Multiplexed Byte-Bus Cycle Sequencer

This block turns read, write and instruction-fetch requests from a 16-bit core into external memory cycles on a multiplexed 8-bit address/data bus. Each byte cycle puts the low address byte on the shared lines during an address phase, marked by the address strobe pin. It then either releases the lines for a read or drives write data, pulses the active-low read or write strobe, and ends with a recovery cycle. The high address byte sits on its own pins for the whole cycle. A 16-bit request becomes two byte cycles, low byte first. The block returns one completion pulse and, for a read, the assembled word.

The address strobe pin has two configured behaviours. In latch-pulse mode it goes high for exactly one clock at the start of each byte cycle. In valid-level mode it is low from the address phase until the recovery cycle. Cycles can be stretched by an external ready input, and a configured limit caps the number of wait states in one cycle. When the external-access input is high, requests whose base address falls in the on-chip window 2000H to 3FFFH finish at once with no bus activity. One clock equals one oscillator period, and two clocks make one state.

Top module: `xbus_seq`

## Requirements
- R1: After reset, and whenever idle, rd_n and wr_n are 1, inst is 0, ad_oe is 0, req_ready is 1, and the strobe pin is at its inactive level (0 in latch-pulse mode, 1 in valid-level mode).
- R2: A byte cycle without wait states holds its read or write strobe low for exactly 2 clocks. Its done arrives on the 4th clock after the request is accepted.
- R3: In latch-pulse mode (cfg_adv_mode=0) the strobe pin is high for exactly one clock per byte cycle. In that clock {addr_hi, ad_out} carries the byte address with ad_oe=1, and rd_n and wr_n are both high.
- R4: In valid-level mode (cfg_adv_mode=1) the strobe pin falls once per byte cycle, at the address phase. It is high again by the first clock after the read or write strobe rises.
- R5: During a read, ad_oe is 0 while rd_n is low. The byte on ad_in is taken at the clock edge where rd_n rises, and a byte read returns it zero-extended in rdata[15:8]=0.
- R6: A write drives its data byte on ad_out with ad_oe=1 while wr_n is low. wr_n goes low exactly once per written byte.
- R7: inst is 1 throughout every byte cycle of a fetch (read with req_fetch=1). It is 0 for data reads and for writes, including fetch-flagged writes.
- R8: The ready input is sampled at the end of the second strobe-low clock and then every 2 clocks. Each low sample adds one wait state (2 clocks of strobe-low time) until cfg_wait_max wait states have been added in that byte cycle.
- R9: A word request (req_word=1) runs two byte cycles at req_addr and req_addr+1, low byte first, and gives one done pulse with rdata = {byte at addr+1, byte at addr}.
- R10: With ea_hi=1 and the request address in 2000H..3FFFH, the block produces no strobe of any kind. It raises done and int_hit on the clock after acceptance. Outside that window, or with ea_hi=0, the access is external.
- R11: done is a single-clock pulse, and req_ready is 0 from acceptance until the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one oscillator period |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_adv_mode | input | 1 | 0: latch-pulse strobe, 1: valid-level strobe |
| cfg_wait_max | input | CAPW | Maximum wait states per byte cycle |
| ea_hi | input | 1 | External-access select; 1 maps the window on-chip |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_word | input | 1 | 1 word (two bytes), 0 byte |
| req_addr | input | AW | Request byte address |
| req_wdata | input | 16 | Write data, low byte used first |
| req_ready | output | 1 | Block can accept a request |
| done | output | 1 | Request complete |
| int_hit | output | 1 | Completion was an on-chip window hit |
| rdata | output | 16 | Read result |
| astb | output | 1 | Address strobe pin |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inst | output | 1 | Instruction-fetch indicator |
| addr_hi | output | AW-8 | Upper address byte |
| ad_out | output | 8 | Shared lines, driven value |
| ad_oe | output | 1 | Shared lines output enable |
| ad_in | input | 8 | Shared lines, received value |
| ready_in | input | 1 | External ready |

## Verification
The bench runs a memory model on the pins, so a wrong phase or wait counter shows up within the same byte cycle. The strobe-low width no longer matches the count expected from the ready hold and the cap, or the done latency shifts by whole 2-clock steps. A lost high-byte flag shows up as a word transfer with the wrong number of strobes or a repeated address on the second cycle. A bad capture point shows up as the idle filler value in rdata. A wrong window decode shows up on the very next clock, as a strobe that should not appear or a missing int_hit.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int AW = 16,
  parameter int CAPW = 2,
  parameter logic [AW-1:0] WIN_LO = 'h2000,
  parameter logic [AW-1:0] WIN_HI = 'h3FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_adv_mode,
  input  logic [CAPW-1:0] cfg_wait_max,
  input  logic            ea_hi,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_fetch,
  input  logic            req_word,
  input  logic [AW-1:0]   req_addr,
  input  logic [15:0]     req_wdata,
  output logic            req_ready,
  output logic            done,
  output logic            int_hit,
  output logic [15:0]     rdata,
  output logic            astb,
  output logic            rd_n,
  output logic            wr_n,
  output logic            inst,
  output logic [AW-9:0]   addr_hi,
  output logic [7:0]      ad_out,
  output logic            ad_oe,
  input  logic [7:0]      ad_in,
  input  logic            ready_in
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_STB, S_HOLD, S_WAIT, S_END, S_INT} st_t;

  st_t             st;
  logic [AW-1:0]   a_q;
  logic [15:0]     wd_q, rd_q;
  logic            wr_q, fe_q, w16_q, hi_q;
  logic [CAPW-1:0] wc_q;

  logic [AW-1:0] cur_addr;
  logic          on_chip, strobing, ext_busy;

  assign cur_addr = a_q + {{(AW-1){1'b0}}, hi_q};
  assign on_chip  = ea_hi && (req_addr >= WIN_LO) && (req_addr <= WIN_HI);
  assign strobing = (st == S_STB) || (st == S_HOLD) || (st == S_WAIT);
  assign ext_busy = strobing || (st == S_ADDR) || (st == S_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      a_q   <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
      wr_q  <= 1'b0;
      fe_q  <= 1'b0;
      w16_q <= 1'b0;
      hi_q  <= 1'b0;
      wc_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          a_q   <= req_addr;
          wd_q  <= req_wdata;
          wr_q  <= req_write;
          fe_q  <= req_fetch;
          w16_q <= req_word;
          hi_q  <= 1'b0;
          wc_q  <= '0;
          rd_q  <= '0;
          st    <= on_chip ? S_INT : S_ADDR;
        end
        S_ADDR: st <= S_STB;
        S_STB:  st <= S_HOLD;
        S_HOLD: begin
          if (!ready_in && (wc_q < cfg_wait_max)) begin
            wc_q <= wc_q + 1'b1;
            st   <= S_WAIT;
          end else begin
            if (!wr_q) begin
              if (hi_q) rd_q[15:8] <= ad_in;
              else      rd_q[7:0]  <= ad_in;
            end
            st <= S_END;
          end
        end
        S_WAIT: st <= S_HOLD;
        S_END: begin
          if (w16_q && !hi_q) begin
            hi_q <= 1'b1;
            wc_q <= '0;
            st   <= S_ADDR;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign int_hit   = (st == S_INT);
  assign done      = int_hit || ((st == S_END) && (!w16_q || hi_q));
  assign rdata     = rd_q;

  assign astb    = cfg_adv_mode ? !(strobing || (st == S_ADDR)) : (st == S_ADDR);
  assign rd_n    = !(strobing && !wr_q);
  assign wr_n    = !(strobing && wr_q);
  assign inst    = ext_busy && fe_q && !wr_q;
  assign addr_hi = ext_busy ? cur_addr[AW-1:8] : '0;
  assign ad_out  = (st == S_ADDR) ? cur_addr[7:0] : (hi_q ? wd_q[15:8] : wd_q[7:0]);
  assign ad_oe   = (st == S_ADDR) || (wr_q && (strobing || (st == S_END)));

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int CAPW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_adv_mode,
  input logic [CAPW-1:0] cfg_wait_max,
  input logic            astb,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic            inst,
  input logic            done,
  input logic            int_hit,
  input logic            req_ready
);

  logic [CAPW+2:0] low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) low_q <= '0;
    else if (!rd_n || !wr_n) low_q <= low_q + 1'b1;
    else low_q <= '0;
  end

  a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);
  a_r3_pulse_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_adv_mode && astb) |-> (rd_n && wr_n));
  a_r3_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_adv_mode && astb) |=> !astb);
  a_r11_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_onchip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    int_hit |-> (done && rd_n && wr_n && !ad_oe));
  a_r7_fetch_not_write: assert property (@(posedge clk) disable iff (!rst_n)
    inst |-> wr_n);
  a_r8_wait_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (int'(low_q) < 2 * int'(cfg_wait_max) + 2));
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

endmodule

bind xbus_seq xbus_seq_chk #(.CAPW(CAPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_adv_mode(cfg_adv_mode), .cfg_wait_max(cfg_wait_max),
  .astb(astb), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .inst(inst),
  .done(done), .int_hit(int_hit), .req_ready(req_ready)
);

// File: tb/xbus_seq_tb_top.sv
module xbus_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_adv_mode = 1'b0;
  logic [1:0]  cfg_wait_max = 2'd0;
  logic        ea_hi = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, done, int_hit, astb, rd_n, wr_n, inst, ad_oe;
  logic [15:0] rdata;
  logic [7:0]  addr_hi, ad_out, ad_in;
  logic        ready_in = 1'b1;

  xbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_adv_mode(cfg_adv_mode), .cfg_wait_max(cfg_wait_max),
    .ea_hi(ea_hi), .req_valid(req_valid), .req_write(req_write), .req_fetch(req_fetch),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .int_hit(int_hit), .rdata(rdata), .astb(astb), .rd_n(rd_n), .wr_n(wr_n),
    .inst(inst), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ready_in(ready_in)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(1'b0, "watchdog", cyc, 190000);
      finish_up();
    end
  end

  // memory model state
  logic [15:0] lat_addr = '0;
  logic [15:0] base_addr = '0;
  int          ncyc = 0, lowcnt = 0, rdy_hold = 0, expw = 0;
  logic        exp_inst = 1'b0;
  logic [7:0]  wlog [2];
  int          wcount = 0;
  logic        prev_astb = 1'b1;
  logic        bfm_on = 1'b0;

  assign ad_in = !rd_n ? mem_byte(lat_addr) : 8'hEE;

  always @(negedge clk) begin
    bit start;
    if (bfm_on) begin
      start = cfg_adv_mode ? (!astb && prev_astb) : astb;
      if (cfg_adv_mode == 1'b0 && astb && prev_astb)
        chk(1'b0, "R3 strobe pulse longer than one clock", 2, 1);
      if (start) begin
        lat_addr = {addr_hi, ad_out};
        chk(ad_oe, "R3 address driven in strobe phase", ad_oe, 1);
        chk(lat_addr == base_addr + 16'(ncyc), "R9 byte address order", lat_addr, base_addr + 16'(ncyc));
        chk(inst == exp_inst, "R7 fetch indicator", inst, exp_inst);
        if (!cfg_adv_mode) chk(rd_n && wr_n, "R3 strobes high during address pulse", {rd_n, wr_n}, 2'b11);
        ncyc++;
      end
      if (!rd_n || !wr_n) begin
        lowcnt++;
        if (lowcnt == 1) begin
          if (!wr_n) begin
            chk(ad_oe, "R6 write data driven", ad_oe, 1);
            if (wcount < 2) wlog[wcount] = ad_out;
            wcount++;
          end else begin
            chk(!ad_oe, "R5 lines released during read", ad_oe, 0);
          end
        end
        if (ext_busy_pin()) chk(inst == exp_inst, "R7 fetch level held", inst, exp_inst);
      end else if (lowcnt > 0) begin
        chk(lowcnt == 2 + 2 * expw, "R8 R2 strobe low width", lowcnt, 2 + 2 * expw);
        if (cfg_adv_mode) chk(astb, "R4 valid level released at recovery", astb, 1);
        else chk(!astb, "R3 no pulse at recovery", astb, 0);
        lowcnt = 0;
      end
      ready_in = !((!rd_n || !wr_n) && lowcnt < 2 + 2 * rdy_hold);
      prev_astb = astb;
    end
  end

  function automatic bit ext_busy_pin();
    return !rd_n || !wr_n;
  endfunction

  task automatic run(input logic wr, input logic fe, input logic wd, input logic [15:0] a,
                     input logic [15:0] d, input int hold);
    bit internal;
    int lat, exp_lat, nb;
    logic [15:0] exp_rd;
    internal = ea_hi && a >= 16'h2000 && a <= 16'h3FFF;
    rdy_hold = hold;
    expw = (hold < int'(cfg_wait_max)) ? hold : int'(cfg_wait_max);
    nb = internal ? 0 : (wd ? 2 : 1);
    exp_lat = internal ? 1 : nb * (4 + 2 * expw);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base_addr = a; ncyc = 0; wcount = 0;
    exp_inst = fe && !wr;
    req_valid = 1'b1; req_write = wr; req_fetch = fe; req_word = wd; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11 busy after accept", req_ready, 0);
    lat = 1;
    while (!done && lat < 300) begin @(negedge clk); lat++; end
    chk(lat == exp_lat, internal ? "R10 on-chip latency" : (wd ? "R9 word latency" : "R2 byte latency"), lat, exp_lat);
    chk(int_hit == internal, "R10 window decision", int_hit, internal);
    if (!wr && !internal) begin
      exp_rd = wd ? {mem_byte(a + 16'd1), mem_byte(a)} : {8'h00, mem_byte(a)};
      chk(rdata == exp_rd, wd ? "R9 word read data" : "R5 byte read data", rdata, exp_rd);
    end
    @(negedge clk);
    chk(!done, "R11 done single pulse", done, 0);
    chk(ncyc == nb, internal ? "R10 no strobe on-chip" : "R4 R9 byte cycle count", ncyc, nb);
    if (wr) begin
      chk(wcount == nb, "R6 write strobe count", wcount, nb);
      if (nb > 0) chk(wlog[0] == d[7:0], "R6 low write byte", wlog[0], d[7:0]);
      if (nb > 1) chk(wlog[1] == d[15:8], "R9 high write byte", wlog[1], d[15:8]);
    end
    while (!req_ready) @(negedge clk);
    chk(rd_n && wr_n && !inst && !ad_oe && (astb == cfg_adv_mode), "R1 idle pins",
        {rd_n, wr_n, inst, ad_oe, astb}, {4'b1100, cfg_adv_mode});
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready && rd_n && wr_n && !inst && !ad_oe && !astb && !done, "R1 reset state",
        {req_ready, rd_n, wr_n, inst, ad_oe, astb, done}, 7'b1110000);
    @(negedge clk);
    rst_n = 1'b1;
    bfm_on = 1'b1;
    // directed corners
    run(1'b0, 1'b0, 1'b0, 16'h1234, 16'h0, 0);       // R2 R5
    run(1'b0, 1'b1, 1'b1, 16'h4567, 16'h0, 0);       // R7 R9
    run(1'b1, 1'b1, 1'b0, 16'h0A0B, 16'hBEEF, 0);    // R6 R7
    ea_hi = 1'b1;
    run(1'b0, 1'b0, 1'b1, 16'h2000, 16'h0, 0);       // R10 low edge
    run(1'b1, 1'b0, 1'b0, 16'h3FFF, 16'h5A5A, 0);    // R10 high edge
    run(1'b0, 1'b0, 1'b0, 16'h1FFF, 16'h0, 0);       // R10 outside
    run(1'b0, 1'b0, 1'b0, 16'h4000, 16'h0, 0);       // R10 outside
    ea_hi = 1'b0;
    run(1'b0, 1'b1, 1'b0, 16'h2500, 16'h0, 0);       // R10 external when low
    cfg_wait_max = 2'd1;
    run(1'b0, 1'b0, 1'b0, 16'h0100, 16'h0, 4);       // R8 capped
    cfg_wait_max = 2'd3;
    run(1'b1, 1'b0, 1'b1, 16'h00FF, 16'hC0DE, 2);    // R8 R9
    cfg_adv_mode = 1'b1;
    @(negedge clk);
    run(1'b1, 1'b0, 1'b1, 16'h7FFE, 16'h1357, 1);    // R4
    run(1'b0, 1'b1, 1'b1, 16'h8001, 16'h0, 3);       // R4 R8
    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic wr, fe, wd;
      logic [15:0] a, d;
      int hold;
      if ((i % 25) == 0) begin
        cfg_adv_mode = 1'($urandom_range(1, 0));
        cfg_wait_max = 2'($urandom_range(3, 0));
        ea_hi = 1'($urandom_range(1, 0));
        @(negedge clk);
        prev_astb = astb;
      end
      wr = 1'($urandom_range(1, 0));
      fe = 1'($urandom_range(1, 0));
      wd = 1'($urandom_range(1, 0));
      a = ($urandom_range(3, 0) == 0) ? 16'(16'h2000 + $urandom_range(16'h1FFF, 0)) : 16'($urandom);
      d = 16'($urandom);
      hold = $urandom_range(4, 0);
      run(wr, fe, wd, a, d, hold);
    end
    finish_up();
  end
endmodule